// File: doc/BRIEF.md
# Shift-and-add address generation unit

This block is a registered execution unit for a processor datapath. It forms array-element addresses from a base operand and an index operand. The index is shifted left by a small constant and added to the base, either at full width or after the index has been cut down to its low 32 bits and zero-extended. The unit also covers three related cases:

- an unsigned-word add with no shift;
- an unsigned-word shift by an immediate amount, with nothing added;
- a plain zero-extension of the low word.

A request is presented with a valid strobe. Exactly one clock later the unit returns the result, an illegal flag and an output valid. An illegal request always yields a zero result. The width parameter `XLEN` selects 64-bit operation (the default) or 32-bit operation. In 32-bit mode every unsigned-word operation is refused as illegal.

Top module: `agu_shadd`

## Requirements
- R1: Op codes 0, 1 and 2 produce base + (index << n) with n = op + 1, wrapping modulo 2^XLEN, and are legal at both widths.
- R2: Op codes 4, 5 and 6 zero-extend the low 32 bits of the index, shift that value left by op - 3 (1, 2 or 3) at full width, and add the base modulo 2^64.
- R3: Op code 3 adds the base to the zero-extended low 32 bits of the index, with no shift.
- R4: Op code 8 returns the low 32 bits of the index with bits 63..32 cleared. The base operand has no effect.
- R5: Op code 7 returns the zero-extended low word of the index shifted left by shamt[5:0] (0 to 63). The base operand has no effect.
- R6: For op code 7, a set shamt[6] makes the request illegal with a zero result. Every other op code ignores the shamt input.
- R7: Op codes 9 to 15 are illegal and produce a zero result.
- R8: With XLEN = 32, op codes 3 to 8 are illegal and produce a zero result.
- R9: out_valid equals in_valid of the previous cycle. Reset (synchronous, active high) clears out_valid.
- R10: While in_valid is low, out_result and out_illegal keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code (0 to 8 legal) |
| src_index | input | XLEN | Index operand |
| src_base | input | XLEN | Base operand |
| shamt | input | 7 | Immediate shift; bit 6 is reserved |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | XLEN | Registered result |
| out_illegal | output | 1 | Registered illegal flag |

## Verification
Random 64-bit operands over all sixteen op codes are fed to a 64-bit instance and a 32-bit instance at the same time. This separates the full-width index path from the zero-extended one, and the two widths' legality rules from each other.

Directed cases target the points where a wrong extension shows up:
- An index with bit 31 set catches sign extension.
- An index whose upper half is all ones catches a missing zero-extension.
- A shift of 63 and a set reserved shift bit probe the immediate path.
- A base of all ones forces the adder to wrap.

Idle cycles with changing inputs confirm that the result holds.

// File: rtl/agu_shadd.sv
module agu_shadd #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src_index,
  input  logic [XLEN-1:0] src_base,
  input  logic [6:0]      shamt,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);

  localparam bit IS64 = (XLEN == 64);
  localparam logic [XLEN-1:0] WMASK = XLEN'(33'h0_FFFF_FFFF);

  logic [XLEN-1:0] idx_w;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] res;
  logic            bad;
  logic [1:0]      n;

  assign idx_w = src_index & WMASK;
  assign n     = (op == 4'd3) ? 2'd0 : op[1:0] + 2'd1;

  always_comb begin
    shifted = (op[3:2] == 2'b00 && op != 4'd3) ? (src_index << n) : (idx_w << n);
    sum     = src_base + shifted;
    res     = '0;
    bad     = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd2: res = sum;
      4'd3, 4'd4, 4'd5, 4'd6: begin
        res = sum;
        bad = !IS64;
      end
      4'd7: begin
        res = idx_w << shamt[5:0];
        bad = shamt[6] || !IS64;
      end
      4'd8: begin
        res = idx_w;
        bad = !IS64;
      end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_result  <= bad ? '0 : res;
      out_illegal <= bad;
    end
  end

endmodule

module agu_shadd_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [3:0]      op,
  input logic [6:0]      shamt,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);
  localparam logic [XLEN-1:0] WMASK = XLEN'(33'h0_FFFF_FFFF);

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  p_valid_drop_r9:   assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  p_reset_clear_r9:  assert property (@(posedge clk) rst |=> !out_valid);
  p_hold_r10:        assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_result) && $stable(out_illegal)));
  p_bad_code_r7:     assert property (@(posedge clk) disable iff (rst) (in_valid && op > 4'd8) |=> (out_illegal && out_result == '0));
  p_zext_upper_r4:   assert property (@(posedge clk) disable iff (rst) (in_valid && op == 4'd8) |=> ((out_result & ~WMASK) == '0));
  p_rsvd_bit_r6:     assert property (@(posedge clk) disable iff (rst) (in_valid && op == 4'd7 && shamt[6]) |=> (out_illegal && out_result == '0));
endmodule

bind agu_shadd agu_shadd_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .shamt(shamt),
  .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/sim_agu_shadd.sv
module sim_agu_shadd;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [63:0] idx = '0, base = '0;
  logic [6:0] sh = '0;
  logic v64, ill64, v32, ill32;
  logic [63:0] r64;
  logic [31:0] r32;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  agu_shadd #(.XLEN(64)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src_index(idx), .src_base(base),
    .shamt(sh), .out_valid(v64), .out_result(r64), .out_illegal(ill64));
  agu_shadd #(.XLEN(32)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src_index(idx[31:0]), .src_base(base[31:0]),
    .shamt(sh), .out_valid(v32), .out_result(r32), .out_illegal(ill32));

  function automatic logic [64:0] model(input logic [3:0] o, input logic [63:0] i, input logic [63:0] b,
                                        input logic [6:0] s, input bit w32);
    logic [63:0] zw = {32'd0, i[31:0]};
    logic [63:0] r;
    bit il = 0;
    case (o)
      4'd0, 4'd1, 4'd2: r = b + (i << (o + 1));
      4'd3: begin r = b + zw; il = w32; end
      4'd4, 4'd5, 4'd6: begin r = b + (zw << (o - 3)); il = w32; end
      4'd7: begin r = zw << s[5:0]; il = w32 || s[6]; end
      4'd8: begin r = zw; il = w32; end
      default: begin r = '0; il = 1; end
    endcase
    if (il) r = '0;
    if (w32) r = {32'd0, r[31:0]};
    return {il, r};
  endfunction

  function automatic string tag(input logic [3:0] o, input logic [6:0] s);
    if (o > 4'd8) return "R7";
    if (o == 4'd7) return s[6] ? "R6" : "R5";
    if (o == 4'd8) return "R4";
    if (o == 4'd3) return "R3";
    if (o >= 4'd4) return "R2";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [63:0] i, input logic [63:0] b, input logic [6:0] s);
    logic [64:0] e64, e32;
    op = o; idx = i; base = b; sh = s; in_valid = 1'b1;
    e64 = model(o, i, b, s, 0);
    e32 = model(o, {32'd0, i[31:0]}, {32'd0, b[31:0]}, s, 1);
    @(negedge clk);
    check(tag(o, s), {ill64, r64}, e64);
    check((o >= 4'd3 && o <= 4'd8) ? "R8" : tag(o, s), {ill32, 32'd0, r32}, e32);
    check("R9", {64'd0, v64}, 65'd1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [64:0] held;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    check("R9", {63'd0, v64, v32}, 65'd0);
    rst = 1'b0;
    run(4'd0, 64'h0000_0000_8000_0000, 64'h1000, 7'd0);
    run(4'd1, 64'hFFFF_FFFF_0000_0010, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0);
    run(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'd5);
    run(4'd3, 64'hFFFF_FFFF_8000_0001, 64'h10, 7'd0);
    run(4'd4, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0);
    run(4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4, 7'd63);
    run(4'd6, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0);
    run(4'd7, 64'hFFFF_FFFF_0000_0001, 64'h55, 7'd63);
    run(4'd7, 64'hFFFF_FFFF_8000_0000, 64'h55, 7'd0);
    run(4'd7, 64'h0000_0000_0000_0003, 64'h0, 7'd64);
    run(4'd8, 64'hFFFF_FFFF_8765_4321, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0);
    run(4'd9, 64'h1, 64'h1, 7'd0);
    run(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0);
    run(4'd1, 64'h8, 64'h8, 7'd0);
    held = {ill64, r64};
    in_valid = 1'b0; op = 4'd0; idx = 64'hDEAD; base = 64'hBEEF;
    @(negedge clk);
    check("R10", {ill64, r64}, held);
    check("R9", {64'd0, v64}, 65'd0);
    @(negedge clk);
    check("R10", {ill64, r64}, held);
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] ri = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      run(4'($urandom), ri, rb, 7'($urandom));
      if (k % 97 == 0) begin
        held = {ill64, r64};
        in_valid = 1'b0; idx = ~idx;
        @(negedge clk);
        check("R10", {ill64, r64}, held);
      end
    end
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R9", {63'd0, v64, v32}, 65'd0);
    finish_run();
  end
endmodule